// File: doc/BRIEF.md
# Legacy Configuration Port Decoder

This block gives a host processor access to device configuration space through two fixed I/O ports. A 32-bit write to the address port (0xCF8 by default) stores a target selector: an enable flag, a bus number, a device/function number and a dword register index. A later access anywhere in the four-byte data window (0xCFC to 0xCFF) becomes one configuration read or write on a downstream request/response channel. The low two bits of the I/O address pick the byte or halfword lane inside the addressed dword.

On the I/O side, `io_be` gives the access width and the data is right-justified: `4'b0001` means byte, `4'b0011` means halfword, and `4'b1111` means dword. The block handles one transaction at a time. It drops `io_ready` from the cycle after it accepts a forwarded access until that access completes. A read completes with a one-cycle `io_rvalid` pulse. An access that the block refuses never reaches the downstream side. If such an access is a read, it returns all ones.

Top module: `cfg_port_bridge`

## Requirements
- R1: After reset: `io_ready` is 1, `cfg_req_valid` and `io_rvalid` are 0, and the stored selector is all zero.
- R2: An accepted `io_wr` with `io_be`=4'b1111 at the address port loads the selector from bit 31 (enable), bits 23:16 (bus), bits 15:8 (devfn) and bits 7:2 (register). A dword read there returns the selector in the same positions, with bits 30:24 and 1:0 read as zero, as an `io_rvalid` pulse one cycle after acceptance.
- R3: A write to the address port or its next three byte addresses with any `io_be` other than 4'b1111 leaves the selector unchanged and issues no request.
- R4: A byte access at window offset k (0..3) issues `cfg_req_be`=1<<k, with the write byte placed in lane k. A read returns lane k in bits 7:0 and zeros above. Every request carries the stored bus and devfn and `cfg_req_reg`={register,2'b00}.
- R5: A halfword access at offset 0 or 2 uses `cfg_req_be` 4'b0011 or 4'b1100. A read returns that halfword in bits 15:0 and zeros above.
- R6: A dword access at offset 0 moves all 32 bits with `cfg_req_be`=4'b1111. A walk over registers 0x00 to 0xFC returns every dword unchanged.
- R7: A halfword at an odd offset, or a dword at a nonzero offset, is not forwarded. If it is a read, it returns 32'hFFFFFFFF.
- R8: While the enable bit is 0, no data-window access is forwarded, reads return 32'hFFFFFFFF, and writes are dropped.
- R9: A stored bus number of MAX_BUS or above blocks the access in the same way as R8.
- R10: `cfg_req_valid` stays high with stable fields until `cfg_req_ready`, and `io_ready` is low while a request is pending.
- R11: A forwarded read waits up to TIMEOUT cycles after downstream acceptance for `cfg_rsp_valid`. If no response comes, it returns 32'hFFFFFFFF, and a later stray response is ignored.
- R12: A forwarded write completes on downstream acceptance with no response awaited.
- R13: An access outside both ports gets no `io_rvalid` and issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | IO_AW | I/O byte address |
| io_be | input | 4 | Access width: 0001 byte, 0011 halfword, 1111 dword |
| io_rd | input | 1 | Read strobe, held until accepted |
| io_wr | input | 1 | Write strobe, held until accepted |
| io_wdata | input | 32 | Right-justified write data |
| io_ready | output | 1 | Block can accept an access this cycle |
| io_rvalid | output | 1 | Read completion pulse |
| io_rdata | output | 32 | Right-justified read data |
| cfg_req_valid | output | 1 | Configuration request pending |
| cfg_req_ready | input | 1 | Downstream accepts the request |
| cfg_req_write | output | 1 | 1 for write, 0 for read |
| cfg_req_bus | output | 8 | Target bus number |
| cfg_req_devfn | output | 8 | Device (7:3) and function (2:0) |
| cfg_req_reg | output | 8 | Dword-aligned register byte offset |
| cfg_req_be | output | 4 | Dword lane enables |
| cfg_req_wdata | output | 32 | Lane-positioned write data |
| cfg_rsp_valid | input | 1 | Read response present |
| cfg_rsp_rdata | input | 32 | Full read dword |

## Verification
A wrong selector field shows up on the next forwarded request. It also shows up on the address-port read-back, which arrives one cycle after acceptance. A wrong lane register makes narrow reads and writes shift the data or the lane enables, and the sweeps over offsets and widths catch that on the first narrow access. A stuck transaction state shows as `io_ready` held low or a missing completion. A timer that is off by one shows at the response boundary: a response in cycle TIMEOUT is taken, and one in cycle TIMEOUT+1 is lost to the all-ones return.

// File: rtl/cfgb_pkg.sv
package cfgb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } txn_state_t;

  typedef struct packed {
    logic        write;
    logic [7:0]  bus;
    logic [7:0]  devfn;
    logic [5:0]  dw;
    logic [3:0]  be;
    logic [31:0] wdata;
  } cfg_req_t;

  function automatic logic [31:0] width_mask(input logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  function automatic logic [31:0] pick_lanes(input logic [31:0] dword,
                                              input logic [1:0]  lane,
                                              input logic [3:0]  be);
    return (dword >> {lane, 3'b000}) & width_mask(be);
  endfunction

endpackage

// File: rtl/cfgb_addr_latch.sv
module cfgb_addr_latch (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] wdata,
  output logic        en,
  output logic [7:0]  bus,
  output logic [7:0]  devfn,
  output logic [5:0]  dw,
  output logic [31:0] readback
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      bus   <= '0;
      devfn <= '0;
      dw    <= '0;
    end else if (load) begin
      en    <= wdata[31];
      bus   <= wdata[23:16];
      devfn <= wdata[15:8];
      dw    <= wdata[7:2];
    end
  end

  assign readback = {en, 7'b0, bus, devfn, dw, 2'b00};
endmodule

// File: rtl/cfgb_lane_steer.sv
module cfgb_lane_steer
  import cfgb_pkg::*;
(
  input  logic [1:0]  lane,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic        aligned,
  output logic [3:0]  be_out,
  output logic [31:0] wdata_out
);
  always_comb begin
    case (be)
      4'b0001: aligned = 1'b1;
      4'b0011: aligned = ~lane[0];
      4'b1111: aligned = (lane == 2'd0);
      default: aligned = 1'b0;
    endcase
    be_out    = 4'(be << lane);
    wdata_out = 32'((wdata & width_mask(be)) << {lane, 3'b000});
  end
endmodule

// File: rtl/cfgb_txn_ctrl.sv
module cfgb_txn_ctrl
  import cfgb_pkg::*;
#(
  parameter int unsigned TIMEOUT = 64,
  localparam int unsigned TO_W = $clog2(TIMEOUT + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fwd,
  input  cfg_req_t    req_in,
  input  logic [1:0]  lane_in,
  input  logic [3:0]  iobe_in,
  input  logic        imm_rd,
  input  logic [31:0] imm_val,
  output logic        idle,
  output logic        rvalid,
  output logic [31:0] rdata,
  output logic        req_valid,
  output cfg_req_t    req_out,
  input  logic        req_ready,
  input  logic        rsp_valid,
  input  logic [31:0] rsp_rdata
);
  txn_state_t  state;
  cfg_req_t    req_q;
  logic [1:0]  lane_q;
  logic [3:0]  iobe_q;
  logic [TO_W-1:0] tmr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      req_q  <= '0;
      lane_q <= '0;
      iobe_q <= '0;
      tmr    <= '0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (fwd) begin
            state  <= ST_ISSUE;
            req_q  <= req_in;
            lane_q <= lane_in;
            iobe_q <= iobe_in;
          end else if (imm_rd) begin
            rvalid <= 1'b1;
            rdata  <= imm_val;
          end
        end
        ST_ISSUE: begin
          if (req_ready) begin
            tmr   <= '0;
            state <= req_q.write ? ST_IDLE : ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            rvalid <= 1'b1;
            rdata  <= pick_lanes(rsp_rdata, lane_q, iobe_q);
            state  <= ST_IDLE;
          end else if (tmr == TO_W'(TIMEOUT - 1)) begin
            rvalid <= 1'b1;
            rdata  <= '1;
            state  <= ST_IDLE;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign req_valid = (state == ST_ISSUE);
  assign req_out   = req_q;
endmodule

// File: rtl/cfg_port_bridge.sv
module cfg_port_bridge
  import cfgb_pkg::*;
#(
  parameter int unsigned IO_AW     = 16,
  parameter int unsigned ADDR_PORT = 'hCF8,
  parameter int unsigned DATA_PORT = 'hCFC,
  parameter int unsigned MAX_BUS   = 256,
  parameter int unsigned TIMEOUT   = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IO_AW-1:0] io_addr,
  input  logic [3:0]       io_be,
  input  logic             io_rd,
  input  logic             io_wr,
  input  logic [31:0]      io_wdata,
  output logic             io_ready,
  output logic             io_rvalid,
  output logic [31:0]      io_rdata,
  output logic             cfg_req_valid,
  input  logic             cfg_req_ready,
  output logic             cfg_req_write,
  output logic [7:0]       cfg_req_bus,
  output logic [7:0]       cfg_req_devfn,
  output logic [7:0]       cfg_req_reg,
  output logic [3:0]       cfg_req_be,
  output logic [31:0]      cfg_req_wdata,
  input  logic             cfg_rsp_valid,
  input  logic [31:0]      cfg_rsp_rdata
);
  localparam logic [IO_AW-1:0] APORT = IO_AW'(ADDR_PORT);
  localparam logic [IO_AW-1:0] DPORT = IO_AW'(DATA_PORT);
  localparam logic [8:0]       BUS_LIM = 9'(MAX_BUS);

  logic        a_en;
  logic [7:0]  a_bus;
  logic [7:0]  a_devfn;
  logic [5:0]  a_dw;
  logic [31:0] a_readback;

  logic        io_go, at_addr, at_data, bus_ok, aligned, pass;
  logic        load, fwd, imm_rd;
  logic [31:0] imm_val;
  logic [3:0]  st_be;
  logic [31:0] st_wdata;
  cfg_req_t    req_in, req_out;

  assign io_go   = (io_rd | io_wr) & io_ready;
  assign at_addr = (io_addr == APORT) && (io_be == 4'hF);
  assign at_data = (io_addr[IO_AW-1:2] == DPORT[IO_AW-1:2]);
  assign bus_ok  = ({1'b0, a_bus} < BUS_LIM);
  assign pass    = a_en & bus_ok & aligned;
  assign load    = io_go & io_wr & at_addr;
  assign fwd     = io_go & at_data & pass;
  assign imm_rd  = io_go & io_rd & (at_addr | (at_data & ~pass));
  assign imm_val = at_addr ? a_readback : '1;

  cfgb_addr_latch u_addr (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .wdata    (io_wdata),
    .en       (a_en),
    .bus      (a_bus),
    .devfn    (a_devfn),
    .dw       (a_dw),
    .readback (a_readback)
  );

  cfgb_lane_steer u_steer (
    .lane      (io_addr[1:0]),
    .be        (io_be),
    .wdata     (io_wdata),
    .aligned   (aligned),
    .be_out    (st_be),
    .wdata_out (st_wdata)
  );

  always_comb begin
    req_in.write = io_wr;
    req_in.bus   = a_bus;
    req_in.devfn = a_devfn;
    req_in.dw    = a_dw;
    req_in.be    = st_be;
    req_in.wdata = st_wdata;
  end

  cfgb_txn_ctrl #(.TIMEOUT(TIMEOUT)) u_txn (
    .clk       (clk),
    .rst       (rst),
    .fwd       (fwd),
    .req_in    (req_in),
    .lane_in   (io_addr[1:0]),
    .iobe_in   (io_be),
    .imm_rd    (imm_rd),
    .imm_val   (imm_val),
    .idle      (io_ready),
    .rvalid    (io_rvalid),
    .rdata     (io_rdata),
    .req_valid (cfg_req_valid),
    .req_out   (req_out),
    .req_ready (cfg_req_ready),
    .rsp_valid (cfg_rsp_valid),
    .rsp_rdata (cfg_rsp_rdata)
  );

  assign cfg_req_write = req_out.write;
  assign cfg_req_bus   = req_out.bus;
  assign cfg_req_devfn = req_out.devfn;
  assign cfg_req_reg   = {req_out.dw, 2'b00};
  assign cfg_req_be    = req_out.be;
  assign cfg_req_wdata = req_out.wdata;
endmodule

// File: rtl/cfgb_checker.sv
module cfgb_checker #(
  parameter int unsigned TIMEOUT = 64
) (
  input logic        clk,
  input logic        rst,
  input logic        io_ready,
  input logic        io_rvalid,
  input logic        cfg_req_valid,
  input logic        cfg_req_ready,
  input logic        cfg_req_write,
  input logic [7:0]  cfg_req_bus,
  input logic [7:0]  cfg_req_devfn,
  input logic [7:0]  cfg_req_reg,
  input logic [3:0]  cfg_req_be,
  input logic [31:0] cfg_req_wdata,
  input logic        addr_en
);
  logic        pending;
  int unsigned wait_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      wait_cnt <= 0;
    end else if (io_rvalid) begin
      pending  <= 1'b0;
      wait_cnt <= 0;
    end else if (cfg_req_valid && cfg_req_ready && !cfg_req_write) begin
      pending  <= 1'b1;
      wait_cnt <= 0;
    end else if (pending) begin
      wait_cnt <= wait_cnt + 1;
    end
  end

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (cfg_req_valid && !cfg_req_ready) |=> (cfg_req_valid && $stable(cfg_req_write)
      && $stable(cfg_req_bus) && $stable(cfg_req_devfn) && $stable(cfg_req_reg)
      && $stable(cfg_req_be) && $stable(cfg_req_wdata)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> (!io_ready && !io_rvalid));

  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(cfg_req_valid) |-> $past(addr_en));

  assert_lane_shape_R4: assert property (@(posedge clk) disable iff (rst)
    cfg_req_valid |-> ($countones(cfg_req_be) == 1 || cfg_req_be == 4'b0011
                       || cfg_req_be == 4'b1100 || cfg_req_be == 4'b1111));

  assert_read_bounded_R11: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= TIMEOUT);
endmodule

bind cfg_port_bridge cfgb_checker #(.TIMEOUT(TIMEOUT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .io_ready      (io_ready),
  .io_rvalid     (io_rvalid),
  .cfg_req_valid (cfg_req_valid),
  .cfg_req_ready (cfg_req_ready),
  .cfg_req_write (cfg_req_write),
  .cfg_req_bus   (cfg_req_bus),
  .cfg_req_devfn (cfg_req_devfn),
  .cfg_req_reg   (cfg_req_reg),
  .cfg_req_be    (cfg_req_be),
  .cfg_req_wdata (cfg_req_wdata),
  .addr_en       (a_en)
);

// File: tb/cfg_port_bridge_test.sv
`timescale 1ns/1ps
module cfg_port_bridge_test;
  localparam int MAXB = 4;
  localparam int TMO  = 8;

  logic        clk = 0;
  logic        rst = 1;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic        io_rd = 0, io_wr = 0;
  logic [31:0] io_wdata = '0;
  logic        io_ready, io_rvalid;
  logic [31:0] io_rdata;
  logic        cfg_req_valid, cfg_req_write;
  logic        cfg_req_ready = 0;
  logic [7:0]  cfg_req_bus, cfg_req_devfn, cfg_req_reg;
  logic [3:0]  cfg_req_be;
  logic [31:0] cfg_req_wdata;
  logic        cfg_rsp_valid = 0;
  logic [31:0] cfg_rsp_rdata = '0;

  always #2.5 clk = ~clk;

  cfg_port_bridge #(.MAX_BUS(MAXB), .TIMEOUT(TMO)) uut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_be(io_be), .io_rd(io_rd),
    .io_wr(io_wr), .io_wdata(io_wdata), .io_ready(io_ready),
    .io_rvalid(io_rvalid), .io_rdata(io_rdata), .cfg_req_valid(cfg_req_valid),
    .cfg_req_ready(cfg_req_ready), .cfg_req_write(cfg_req_write),
    .cfg_req_bus(cfg_req_bus), .cfg_req_devfn(cfg_req_devfn),
    .cfg_req_reg(cfg_req_reg), .cfg_req_be(cfg_req_be),
    .cfg_req_wdata(cfg_req_wdata), .cfg_rsp_valid(cfg_rsp_valid),
    .cfg_rsp_rdata(cfg_rsp_rdata)
  );

  int checks = 0, fails = 0, stall_viol = 0;
  bit done = 0;

  function automatic logic [31:0] tgt_word(input logic [7:0] b, input logic [7:0] df,
                                           input logic [7:0] r);
    return {r ^ 8'hC3, df, b ^ 8'h5A, r + 8'h11};
  endfunction

  // downstream target model
  int rdy_dly = 0, rsp_lat = 1, wcnt = 0, rsp_cd = -1, req_count = 0;
  logic        cap_w, last_w;
  logic [7:0]  cap_b, cap_d, cap_r, last_b, last_d, last_r;
  logic [3:0]  cap_be, last_be;
  logic [31:0] cap_wd, last_wd;

  initial begin
    forever begin
      @(negedge clk);
      cfg_rsp_valid = 0;
      if (cfg_req_ready) begin
        cfg_req_ready = 0;
        req_count++;
        last_w = cap_w; last_b = cap_b; last_d = cap_d; last_r = cap_r;
        last_be = cap_be; last_wd = cap_wd;
        if (!cap_w) rsp_cd = rsp_lat;
        wcnt = 0;
      end else if (cfg_req_valid) begin
        if (wcnt >= rdy_dly) begin
          cfg_req_ready = 1;
          cap_w = cfg_req_write; cap_b = cfg_req_bus; cap_d = cfg_req_devfn;
          cap_r = cfg_req_reg; cap_be = cfg_req_be; cap_wd = cfg_req_wdata;
        end else wcnt++;
      end
      if (rsp_cd == 0) begin
        cfg_rsp_valid = 1;
        cfg_rsp_rdata = tgt_word(last_b, last_d, last_r);
        rsp_cd = -1;
      end else if (rsp_cd > 0) rsp_cd--;
    end
  end

  always @(negedge clk) if (!rst && cfg_req_valid && io_ready) stall_viol++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic io_op(input bit wr, input logic [15:0] a, input logic [3:0] be,
                       input logic [31:0] wd, output bit got, output logic [31:0] rd);
    @(negedge clk);
    io_rd = !wr; io_wr = wr; io_addr = a; io_be = be; io_wdata = wd;
    while (!io_ready) @(negedge clk);
    @(negedge clk);
    io_rd = 0; io_wr = 0;
    got = 0; rd = '0;
    if (wr) begin
      while (!io_ready) @(negedge clk);
      @(negedge clk);
    end else begin
      for (int i = 0; i < 40; i++) begin
        if (io_rvalid) begin got = 1; rd = io_rdata; break; end
        @(negedge clk);
      end
      @(negedge clk);
    end
  endtask

  task automatic set_sel(input bit en, input logic [7:0] b, input logic [7:0] df,
                         input logic [5:0] dw);
    bit g; logic [31:0] r;
    io_op(1, 16'hCF8, 4'hF, {en, 7'h55, b, df, dw, 2'b10}, g, r);
  endtask

  function automatic logic [31:0] sel_val(input bit en, input logic [7:0] b,
                                          input logic [7:0] df, input logic [5:0] dw);
    return {en, 7'h0, b, df, dw, 2'b00};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit g; logic [31:0] r, exp, w; int rc;
    logic [7:0] dfs [3];
    dfs[0] = 8'h00; dfs[1] = 8'h08; dfs[2] = 8'hFF;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    check(io_ready === 1'b1, "R1 io_ready", {31'b0, io_ready}, 1);
    check(cfg_req_valid === 1'b0 && io_rvalid === 1'b0, "R1 valids",
          {30'b0, cfg_req_valid, io_rvalid}, 0);
    io_op(0, 16'hCF8, 4'hF, 0, g, r);
    check(g && r === 32'h0, "R1 selector zero", r, 0);

    // R2 load and read back
    set_sel(1, 8'h02, 8'h1A, 6'h2D);
    io_op(0, 16'hCF8, 4'hF, 0, g, r);
    exp = sel_val(1, 8'h02, 8'h1A, 6'h2D);
    check(g && r === exp, "R2 readback", r, exp);

    // R3 narrow writes at the address port ignored
    rc = req_count;
    io_op(1, 16'hCF8, 4'b0001, 32'h0000_0000, g, r);
    io_op(1, 16'hCFA, 4'b0011, 32'h0000_FFFF, g, r);
    io_op(1, 16'hCFB, 4'b0001, 32'h0000_0000, g, r);
    io_op(0, 16'hCF8, 4'hF, 0, g, r);
    check(g && r === exp, "R3 selector unchanged", r, exp);
    check(req_count == rc, "R3 no request", req_count, rc);

    // R6 dword walk over several bus/devfn with varied handshake delays
    for (int b = 0; b < MAXB; b++)
      for (int d = 0; d < 3; d++)
        for (int dw = 0; dw < 64; dw++) begin
          rdy_dly = dw % 3; rsp_lat = dw % 4;
          set_sel(1, 8'(b), dfs[d], 6'(dw));
          io_op(0, 16'hCFC, 4'hF, 0, g, r);
          exp = tgt_word(8'(b), dfs[d], 8'(dw * 4));
          check(g && r === exp, "R6 dword read", r, exp);
          check(last_b == 8'(b) && last_d == dfs[d] && last_r == 8'(dw * 4) && last_be == 4'hF,
                "R4 request fields", {last_b, last_d, last_r, 4'h0, last_be},
                {8'(b), dfs[d], 8'(dw * 4), 8'h0F});
        end

    // R4 byte and R5 halfword reads and writes
    for (int dw = 0; dw < 64; dw += 9) begin
      rdy_dly = 1; rsp_lat = 2;
      set_sel(1, 8'h03, 8'h21, 6'(dw));
      w = tgt_word(8'h03, 8'h21, 8'(dw * 4));
      for (int k = 0; k < 4; k++) begin
        io_op(0, 16'hCFC + 16'(k), 4'b0001, 0, g, r);
        exp = {24'h0, w[8*k +: 8]};
        check(g && r === exp, "R4 byte read", r, exp);
        io_op(1, 16'hCFC + 16'(k), 4'b0001, 32'hFFFF_FF00 | 32'(k + 16), g, r);
        exp = 32'(k + 16) << (8 * k);
        check(last_w && last_be == 4'(1 << k) && last_wd === exp, "R4 byte write",
              last_wd, exp);
      end
      for (int k = 0; k < 4; k += 2) begin
        io_op(0, 16'hCFC + 16'(k), 4'b0011, 0, g, r);
        exp = {16'h0, w[8*k +: 16]};
        check(g && r === exp, "R5 halfword read", r, exp);
        io_op(1, 16'hCFC + 16'(k), 4'b0011, 32'hABCD_1234 + 32'(dw), g, r);
        exp = 32'(16'h1234 + 16'(dw)) << (8 * k);
        check(last_w && last_be == (k == 0 ? 4'b0011 : 4'b1100) && last_wd === exp,
              "R5 halfword write", last_wd, exp);
      end
      io_op(1, 16'hCFC, 4'hF, 32'h1357_9BDF ^ 32'(dw), g, r);
      exp = 32'h1357_9BDF ^ 32'(dw);
      check(last_w && last_be == 4'hF && last_wd === exp, "R6 dword write", last_wd, exp);
    end

    // R12 write completes without response
    rdy_dly = 3; rc = req_count;
    io_op(1, 16'hCFC, 4'hF, 32'h0BAD_F00D, g, r);
    check(req_count == rc + 1 && io_ready, "R12 write completes", req_count, rc + 1);

    // R7 misaligned
    rdy_dly = 0; rc = req_count;
    io_op(0, 16'hCFD, 4'b0011, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R7 odd halfword", r, 32'hFFFF_FFFF);
    io_op(0, 16'hCFE, 4'hF, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R7 offset dword", r, 32'hFFFF_FFFF);
    io_op(1, 16'hCFF, 4'b0011, 32'h1, g, r);
    check(req_count == rc, "R7 no request", req_count, rc);

    // R8 enable clear
    set_sel(0, 8'h01, 8'h10, 6'h04);
    io_op(0, 16'hCFC, 4'hF, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R8 disabled read", r, 32'hFFFF_FFFF);
    io_op(0, 16'hCFD, 4'b0001, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R8 disabled byte read", r, 32'hFFFF_FFFF);
    io_op(1, 16'hCFC, 4'hF, 32'h5, g, r);
    check(req_count == rc, "R8 no request", req_count, rc);

    // R9 bus limit
    set_sel(1, 8'(MAXB), 8'h10, 6'h04);
    io_op(0, 16'hCFC, 4'hF, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R9 bus at limit", r, 32'hFFFF_FFFF);
    set_sel(1, 8'hFF, 8'h10, 6'h04);
    io_op(1, 16'hCFC, 4'hF, 32'h5, g, r);
    io_op(0, 16'hCFE, 4'b0011, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R9 bus 255", r, 32'hFFFF_FFFF);
    check(req_count == rc, "R9 no request", req_count, rc);

    // R11 timeout boundary
    set_sel(1, 8'h01, 8'h33, 6'h05);
    w = tgt_word(8'h01, 8'h33, 8'h14);
    rsp_lat = TMO - 1;
    io_op(0, 16'hCFC, 4'hF, 0, g, r);
    check(g && r === w, "R11 last-cycle response", r, w);
    rsp_lat = TMO;
    io_op(0, 16'hCFC, 4'hF, 0, g, r);
    check(g && r === 32'hFFFF_FFFF, "R11 timeout ones", r, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    rsp_lat = 1;
    io_op(0, 16'hCFE, 4'b0011, 0, g, r);
    check(g && r === {16'h0, w[31:16]}, "R11 stray response ignored", r, {16'h0, w[31:16]});

    // R13 unclaimed addresses
    rc = req_count;
    io_op(0, 16'h0080, 4'hF, 0, g, r);
    check(!g, "R13 no completion", {31'b0, g}, 0);
    io_op(0, 16'hCFA, 4'b0011, 0, g, r);
    check(!g, "R13 narrow address-port read", {31'b0, g}, 0);
    io_op(1, 16'h0CF0, 4'hF, 0, g, r);
    check(req_count == rc, "R13 no request", req_count, rc);

    // R10 no acceptance while a request is pending
    check(stall_viol == 0, "R10 stall", stall_viol, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule